// File: doc/BRIEF.md
# I2C Interrupt Status and Mask Bank

This block holds the interrupt register set of an I2C host controller. Event pulses from the transfer engine set sticky status bits. Software clears those bits by writing ones to the status register. The mask register cannot be written directly. Software changes it through two write-only registers: one unmasks sources and the other masks them. A single level-sensitive interrupt line is high while any status bit is set and its mask bit is clear.

The bank also holds the controller's 8-bit timeout register. All registers sit behind a simple synchronous port: a write takes effect at the rising clock edge, and read data is a combinational function of the address. Registers are 32 bits wide at word-aligned byte offsets. The status register is at 0x10, the timeout register at 0x1C, the mask at 0x20, the unmask (enable) register at 0x24 and the mask-set (disable) register at 0x28.

The source bits are:

| Bit | Source |
|-----|--------|
| 0 | transfer done |
| 1 | data |
| 2 | NACK |
| 3 | timeout |
| 4 | target ready |
| 5 | receive overflow |
| 6 | transmit overflow |
| 7 | receive underflow |
| 9 | arbitration lost |

Bit 8 is reserved.

Top module: `i2c_irq_bank`

## Requirements
- R1: After reset, the status register reads 0, the mask register reads 0x2FF (every implemented source masked), the timeout register reads 0xFF and `irq_o` is low.
- R2: A high pulse on `hw_event_i[n]` for an implemented bit n sets status bit n at that clock edge. The bit stays set after the pulse ends.
- R3: A write to the status offset clears exactly the status bits written as 1. Status bits written as 0 keep their value.
- R4: When an event and a clear of the same status bit occur in the same cycle, the event wins and the bit reads 1 afterwards.
- R5: A write to the enable offset clears each mask bit written as 1. Mask bits written as 0 keep their value.
- R6: A write to the disable offset sets each implemented mask bit written as 1. Mask bits written as 0 keep their value.
- R7: A write to the mask offset has no effect on the mask. The enable and disable offsets read as 0.
- R8: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. It follows the register state in the same cycle.
- R9: Reserved bit 8 and bits 31..10 of the status and mask registers always read 0. An event on bit 8 sets nothing.
- R10: The timeout register stores bits 7..0 of a write to offset 0x1C and reads them back with bits 31..8 as 0.
- R11: A read of any unmapped offset returns 0. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe |
| reg_addr_i | input | 6 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| hw_event_i | input | 10 | Event pulses from the transfer engine, one per source bit |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions take two things for granted. First, each register access is one write strobe with a stable address and data for that cycle. Second, events arrive as synchronous pulses on the same clock, so the clear-versus-event ordering is decided at a single edge. The stimulus drives every input one time unit after the rising edge and holds it for exactly one cycle. It combines an event with a clear only in the dedicated collision case. It also pulses the reserved bit 8 alongside real sources, so both the sticky path and the reserved-bit tie-off are exercised.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned NUM_SRC = 10;
  localparam int unsigned TMO_W   = 8;

  // byte offsets, word aligned; order fixed by the controller register map
  localparam int unsigned OFF_STATUS  = 'h10;
  localparam int unsigned OFF_TIMEOUT = 'h1C;
  localparam int unsigned OFF_MASK    = 'h20;
  localparam int unsigned OFF_UNMASK  = 'h24;
  localparam int unsigned OFF_SETMASK = 'h28;

  typedef enum int unsigned {
    SRC_DONE     = 0,
    SRC_DATA     = 1,
    SRC_NACK     = 2,
    SRC_TMO      = 3,
    SRC_TGT_RDY  = 4,
    SRC_RX_OVF   = 5,
    SRC_TX_OVF   = 6,
    SRC_RX_UNF   = 7,
    SRC_ARB_LOST = 9
  } irq_src_e;

  localparam logic [NUM_SRC-1:0] SRC_IMPL =
      (NUM_SRC'(1) << SRC_DONE)    | (NUM_SRC'(1) << SRC_DATA)   |
      (NUM_SRC'(1) << SRC_NACK)    | (NUM_SRC'(1) << SRC_TMO)    |
      (NUM_SRC'(1) << SRC_TGT_RDY) | (NUM_SRC'(1) << SRC_RX_OVF) |
      (NUM_SRC'(1) << SRC_TX_OVF)  | (NUM_SRC'(1) << SRC_RX_UNF) |
      (NUM_SRC'(1) << SRC_ARB_LOST);

endpackage

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
  parameter int unsigned       NUM_SRC = 10,
  parameter logic [NUM_SRC-1:0] IMPL   = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);

  logic unused_lanes;
  assign unused_lanes = ^((event_i | clr_i) & ~IMPL);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    if (IMPL[i]) begin : g_impl
      logic st_q;
      // set dominates clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         st_q <= 1'b0;
        else if (event_i[i]) st_q <= 1'b1;
        else if (clr_i[i])   st_q <= 1'b0;
      end
      assign status_o[i] = st_q;
    end else begin : g_rsvd
      assign status_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/i2c_irq_mask.sv
module i2c_irq_mask #(
  parameter int unsigned       NUM_SRC = 10,
  parameter logic [NUM_SRC-1:0] IMPL   = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] unmask_i,
  input  logic [NUM_SRC-1:0] setmask_i,
  output logic [NUM_SRC-1:0] mask_o
);

  logic unused_lanes;
  assign unused_lanes = ^((unmask_i | setmask_i) & ~IMPL);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    if (IMPL[i]) begin : g_impl
      logic m_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           m_q <= 1'b1;
        else if (setmask_i[i]) m_q <= 1'b1;
        else if (unmask_i[i])  m_q <= 1'b0;
      end
      assign mask_o[i] = m_q;
    end else begin : g_rsvd
      assign mask_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/i2c_irq_timeout.sv
module i2c_irq_timeout #(
  parameter int unsigned     TMO_W   = 8,
  parameter logic [TMO_W-1:0] TMO_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [TMO_W-1:0] wdata_i,
  output logic [TMO_W-1:0] tmo_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tmo_o <= TMO_RST;
    else if (we_i) tmo_o <= wdata_i;
  end

endmodule

// File: rtl/i2c_irq_bank.sv
module i2c_irq_bank
  import i2c_irq_pkg::*;
#(
  parameter int unsigned        P_DATA_W  = DATA_W,
  parameter int unsigned        P_ADDR_W  = ADDR_W,
  parameter int unsigned        P_NUM_SRC = NUM_SRC,
  parameter int unsigned        P_TMO_W   = TMO_W,
  parameter logic [P_TMO_W-1:0] P_TMO_RST = '1,
  parameter logic [P_NUM_SRC-1:0] P_IMPL  = SRC_IMPL
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [P_ADDR_W-1:0]  reg_addr_i,
  input  logic [P_DATA_W-1:0]  reg_wdata_i,
  output logic [P_DATA_W-1:0]  reg_rdata_o,
  input  logic [P_NUM_SRC-1:0] hw_event_i,
  output logic                 irq_o
);

  localparam logic [P_ADDR_W-1:0] A_STATUS  = P_ADDR_W'(OFF_STATUS);
  localparam logic [P_ADDR_W-1:0] A_TIMEOUT = P_ADDR_W'(OFF_TIMEOUT);
  localparam logic [P_ADDR_W-1:0] A_MASK    = P_ADDR_W'(OFF_MASK);
  localparam logic [P_ADDR_W-1:0] A_UNMASK  = P_ADDR_W'(OFF_UNMASK);
  localparam logic [P_ADDR_W-1:0] A_SETMASK = P_ADDR_W'(OFF_SETMASK);

  logic                 st_wr, tmo_wr, unm_wr, setm_wr;
  logic [P_NUM_SRC-1:0] wr_bits;
  logic [P_NUM_SRC-1:0] status_q, mask_q;
  logic [P_TMO_W-1:0]   tmo_q;

  localparam int unsigned HI_W = (P_DATA_W > P_NUM_SRC) ? P_DATA_W : P_NUM_SRC + 1;
  logic unused_wdata;
  assign unused_wdata = ^{1'b0, HI_W'(reg_wdata_i) >> P_NUM_SRC};

  assign wr_bits = reg_wdata_i[P_NUM_SRC-1:0];
  assign st_wr   = reg_we_i && (reg_addr_i == A_STATUS);
  assign tmo_wr  = reg_we_i && (reg_addr_i == A_TIMEOUT);
  assign unm_wr  = reg_we_i && (reg_addr_i == A_UNMASK);
  assign setm_wr = reg_we_i && (reg_addr_i == A_SETMASK);

  i2c_irq_status #(
    .NUM_SRC (P_NUM_SRC),
    .IMPL    (P_IMPL)
  ) status_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (hw_event_i & P_IMPL),
    .clr_i    (st_wr ? wr_bits : '0),
    .status_o (status_q)
  );

  i2c_irq_mask #(
    .NUM_SRC (P_NUM_SRC),
    .IMPL    (P_IMPL)
  ) mask_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unmask_i  (unm_wr ? wr_bits : '0),
    .setmask_i (setm_wr ? wr_bits : '0),
    .mask_o    (mask_q)
  );

  i2c_irq_timeout #(
    .TMO_W   (P_TMO_W),
    .TMO_RST (P_TMO_RST)
  ) timeout_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tmo_wr),
    .wdata_i (reg_wdata_i[P_TMO_W-1:0]),
    .tmo_o   (tmo_q)
  );

  // write-only and unmapped offsets read zero
  always_comb begin
    unique case (reg_addr_i)
      A_STATUS:  reg_rdata_o = P_DATA_W'(status_q);
      A_MASK:    reg_rdata_o = P_DATA_W'(mask_q);
      A_TIMEOUT: reg_rdata_o = P_DATA_W'(tmo_q);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(status_q & ~mask_q);

endmodule

// File: rtl/i2c_irq_bank_chk.sv
module i2c_irq_bank_chk
  import i2c_irq_pkg::*;
#(
  parameter int unsigned        P_DATA_W  = DATA_W,
  parameter int unsigned        P_ADDR_W  = ADDR_W,
  parameter int unsigned        P_NUM_SRC = NUM_SRC,
  parameter int unsigned        P_TMO_W   = TMO_W,
  parameter logic [P_NUM_SRC-1:0] P_IMPL  = SRC_IMPL
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [P_ADDR_W-1:0]  reg_addr_i,
  input logic [P_DATA_W-1:0]  reg_wdata_i,
  input logic [P_NUM_SRC-1:0] hw_event_i,
  input logic [P_NUM_SRC-1:0] status_q,
  input logic [P_NUM_SRC-1:0] mask_q,
  input logic [P_TMO_W-1:0]   tmo_q,
  input logic                 irq_o
);

  logic                 c_st_wr, c_unm_wr, c_setm_wr, c_tmo_wr;
  logic [P_NUM_SRC-1:0] c_bits, c_ev;

  assign c_bits    = reg_wdata_i[P_NUM_SRC-1:0] & P_IMPL;
  assign c_ev      = hw_event_i & P_IMPL;
  assign c_st_wr   = reg_we_i && (reg_addr_i == P_ADDR_W'(OFF_STATUS));
  assign c_unm_wr  = reg_we_i && (reg_addr_i == P_ADDR_W'(OFF_UNMASK));
  assign c_setm_wr = reg_we_i && (reg_addr_i == P_ADDR_W'(OFF_SETMASK));
  assign c_tmo_wr  = reg_we_i && (reg_addr_i == P_ADDR_W'(OFF_TIMEOUT));

  assert_event_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|c_ev) |=> ((status_q & $past(c_ev)) == $past(c_ev)));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_st_wr && (c_ev == '0)) |=> ((status_q & $past(c_bits)) == '0));

  assert_event_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_st_wr && |(c_ev & c_bits)) |=> ((status_q & $past(c_ev & c_bits)) != '0));

  assert_unmask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_unm_wr |=> ((mask_q & $past(c_bits)) == '0));

  assert_setmask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_setm_wr |=> ((mask_q & $past(c_bits)) == $past(c_bits)));

  assert_mask_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(c_unm_wr || c_setm_wr) |=> $stable(mask_q));

  assert_irq_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~mask_q) == '0) |-> !irq_o);

  assert_tmo_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_tmo_wr |=> $stable(tmo_q));

endmodule

bind i2c_irq_bank i2c_irq_bank_chk #(
  .P_DATA_W  (P_DATA_W),
  .P_ADDR_W  (P_ADDR_W),
  .P_NUM_SRC (P_NUM_SRC),
  .P_TMO_W   (P_TMO_W),
  .P_IMPL    (P_IMPL)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .hw_event_i  (hw_event_i),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .tmo_q       (tmo_q),
  .irq_o       (irq_o)
);

// File: tb/i2c_irq_bank_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_bank_tb_top;

  localparam logic [5:0] A_ST  = 6'h10;
  localparam logic [5:0] A_TMO = 6'h1C;
  localparam logic [5:0] A_MSK = 6'h20;
  localparam logic [5:0] A_EN  = 6'h24;
  localparam logic [5:0] A_DIS = 6'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  ev = '0;
  logic        irq;
  logic        mon_req = 1'b0;
  logic        done = 1'b0;
  int          checks = 0;
  int          errors = 0;

  typedef struct {
    logic [31:0] exp;
    logic        is_irq;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  i2c_irq_bank dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .hw_event_i  (ev),
    .irq_o       (irq)
  );

  // monitor: compares at the falling edge inside the request cycle
  always @(negedge clk) begin
    if (mon_req && sb_q.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    we = 1'b0; ev = '0; mon_req = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [9:0] e = '0);
    we = 1'b1; addr = a; wdata = d; ev = e;
    step();
  endtask

  task automatic pulse(input logic [9:0] e);
    ev = e;
    step();
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    exp_t it;
    it.exp = exp; it.is_irq = 1'b0; it.tag = tag;
    sb_q.push_back(it);
    addr = a; mon_req = 1'b1;
    step();
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    exp_t it;
    it.exp = {31'b0, exp}; it.is_irq = 1'b1; it.tag = tag;
    sb_q.push_back(it);
    mon_req = 1'b1;
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    rd(A_ST,  32'h0,   "R1 status reset");
    rd(A_MSK, 32'h2FF, "R1 mask reset");
    rd(A_TMO, 32'hFF,  "R1 timeout reset");
    chk_irq(1'b0,      "R1 irq reset");

    pulse(10'h3FF);
    step();
    rd(A_ST, 32'h2FF, "R2 R9 sticky status, bit8 ignored");
    chk_irq(1'b0,     "R8 all masked");

    wr(A_ST, 32'h005);
    rd(A_ST, 32'h2FA, "R3 clear ones only");
    wr(A_ST, 32'h000);
    rd(A_ST, 32'h2FA, "R3 zero write no effect");

    wr(A_EN, 32'h002);
    rd(A_MSK, 32'h2FD, "R5 unmask bit1");
    chk_irq(1'b1,      "R8 unmasked pending");
    wr(A_DIS, 32'h002);
    rd(A_MSK, 32'h2FF, "R6 mask bit1");
    chk_irq(1'b0,      "R8 remasked");

    wr(A_EN, 32'h2E7);
    rd(A_MSK, 32'h018, "R5 master sources");
    chk_irq(1'b1,      "R8 master pending");
    wr(A_ST, 32'h3FF);
    rd(A_ST, 32'h0,    "R3 clear all");
    chk_irq(1'b0,      "R8 cleared");

    wr(A_ST, 32'h001, 10'h001);
    rd(A_ST, 32'h001,  "R4 event beats clear");
    chk_irq(1'b1,      "R4 irq after collision");
    wr(A_ST, 32'h001);
    rd(A_ST, 32'h0,    "R3 clear bit0");

    pulse(10'h008);
    rd(A_ST, 32'h008,  "R2 timeout source");
    chk_irq(1'b0,      "R8 timeout masked");
    wr(A_EN, 32'h008);
    chk_irq(1'b1,      "R8 timeout unmasked");
    wr(A_ST, 32'h008);
    chk_irq(1'b0,      "R8 timeout cleared");

    wr(A_MSK, 32'hFFFF_FFFF);
    rd(A_MSK, 32'h010, "R7 mask write ignored");
    rd(A_EN,  32'h0,   "R7 enable reads zero");
    rd(A_DIS, 32'h0,   "R7 disable reads zero");

    wr(A_DIS, 32'hFFFF_FFFF);
    rd(A_MSK, 32'h2FF, "R9 reserved mask bits zero");

    wr(A_TMO, 32'hABCD_1234);
    rd(A_TMO, 32'h34,  "R10 timeout low byte");

    pulse(10'h200);
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h00, 32'h0,   "R11 unmapped read zero");
    rd(6'h3C, 32'h0,   "R11 unmapped read zero");
    rd(A_ST,  32'h200, "R11 status untouched");
    rd(A_MSK, 32'h2FF, "R11 mask untouched");
    rd(A_TMO, 32'h34,  "R11 timeout untouched");

    step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule